// File: doc/BRIEF.md
# Spin-Flip Acceptance Unit

This block decides the next value of one central spin in a Monte Carlo lattice update. Each cycle it may receive a neighborhood word: the current central spin plus up to twelve neighbor spins. It folds that word into a 10-bit index, reads a 32-bit acceptance probability from a table that the host has filled, and compares the probability with a 32-bit uniform random word supplied by an external generator. The result is the new central spin. A strobe marks each update whose result differs from the old value, so that the spin memory only has to be written on an actual flip.

Two index layouts are supported, chosen by a select input. The square layout passes the central spin and eight surrounding neighbors straight through. The triangular layout passes the central spin and six nearest neighbors straight through, and folds the six next-nearest neighbors into a count of bonds unlike the central spin, so that every arrangement with the same count shares one table entry. A separate host port writes the table and reads it back. Spins are coded as 1 for +1 and 0 for −1.

Top module: `spin_accept_unit`

## Requirements
- R1: With `lat_sel`=0 (square), the table index is {0, center_spin, nbr_bits[7:0]}, with nbr_bits[7:0] in bits 7..0 and the central spin in bit 8; nbr_bits[11:8] have no effect on the result.
- R2: With `lat_sel`=1 (triangular), the table index is {center_spin, nbr_bits[5:0], unlike_count}, with the central spin in bit 9, nbr_bits[5:0] in bits 8..3 and the 3-bit count in bits 2..0.
- R3: The unlike count is the number of bits in nbr_bits[11:6] that differ from center_spin, from 0 to 6; arrangements with equal count give equal results.
- R4: The new spin is 1 when the table entry is strictly greater than `rnd_word` as unsigned numbers, and 0 otherwise, including when they are equal.
- R5: `flip_stb` is high exactly in a cycle where `out_vld` is high and `new_spin` differs from the central spin that came with that update.
- R6: An input presented with `in_vld` high at one rising edge produces its `out_vld`, `new_spin` and `flip_stb` after the second rising edge; back-to-back inputs give back-to-back results.
- R7: `host_rdata` holds, after a rising edge, the table entry at the `host_addr` sampled at that edge; when `host_we` writes that same entry at that edge, the old content is returned and the new content is returned on the next read.
- R8: While `rst` is high, `out_vld` and `flip_stb` are 0 after each rising edge, whatever the input.
- R9: A cycle with `in_vld` low produces, two edges later, `out_vld` and `flip_stb` both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lat_sel | input | 1 | Index layout: 0 square, 1 triangular |
| in_vld | input | 1 | Neighborhood word and random word are valid |
| center_spin | input | 1 | Current central spin (1 = +1) |
| nbr_bits | input | 12 | Neighbor spins |
| rnd_word | input | 32 | Uniform random word for the compare |
| host_we | input | 1 | Host table write enable |
| host_addr | input | 10 | Host table index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host readback data, one edge after the index |
| out_vld | output | 1 | Result valid |
| new_spin | output | 1 | New central spin |
| flip_stb | output | 1 | New spin differs from the old one |

## Verification
Lookup results are due after the second rising edge following the edge that samples the input, while host readback is due after the first. The bench drives inputs on the falling edge, pushes the expected lookup result into a queue that is one entry deep ahead of the design, and at every following falling edge pops and compares, so each cycle is compared with the input from two edges before, including idle cycles. Readback is compared on the falling edge right after the edge that sampled the index. Every index-layout check pairs a random word equal to the expected entry with one just below it, so a wrong index shows as a wrong spin.

// File: rtl/spin_accept_pkg.sv
package spin_accept_pkg;
  typedef enum logic {
    LAT_SQUARE = 1'b0,
    LAT_TRI    = 1'b1
  } lattice_e;
endpackage

// File: rtl/nbr_addr_former.sv
module nbr_addr_former
  import spin_accept_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NBR_W  = 12,
  parameter int SQ_W   = 8,
  parameter int NEAR_W = 6,
  parameter int FAR_W  = 6,
  parameter int CNT_W  = 3
) (
  input  lattice_e            lat,
  input  logic                center,
  input  logic [NBR_W-1:0]    nbr,
  output logic [ADDR_W-1:0]   addr
);
  logic [FAR_W-1:0]  unlike;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] sq_addr;
  logic [ADDR_W-1:0] tri_addr;

  // one bond comparator per next-nearest neighbor
  for (genvar i = 0; i < FAR_W; i++) begin : g_bond
    assign unlike[i] = nbr[NEAR_W+i] ^ center;
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < FAR_W; i++) begin
      cnt = cnt + CNT_W'(unlike[i]);
    end
  end

  assign sq_addr  = ADDR_W'({center, nbr[SQ_W-1:0]});
  assign tri_addr = ADDR_W'({center, nbr[NEAR_W-1:0], cnt});

  always_comb begin
    unique case (lat)
      LAT_TRI: addr = tri_addr;
      default: addr = sq_addr;
    endcase
  end
endmodule

// File: rtl/prob_table.sv
module prob_table #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic [DATA_W-1:0] lk_data,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // host port: read-before-write
  always_ff @(posedge clk) begin
    if (h_we) mem[h_addr] <= h_wdata;
    h_rdata <= mem[h_addr];
  end

  // lookup port: read only
  always_ff @(posedge clk) begin
    lk_data <= mem[lk_addr];
  end
endmodule

// File: rtl/accept_compare.sv
module accept_compare #(
  parameter int PROB_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_in,
  input  logic              ctr_in,
  input  logic [PROB_W-1:0] prob,
  input  logic [PROB_W-1:0] rnd,
  output logic              out_vld,
  output logic              new_spin,
  output logic              flip_stb
);
  logic decide;
  assign decide = prob > rnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      new_spin <= 1'b0;
      flip_stb <= 1'b0;
    end else begin
      out_vld  <= vld_in;
      if (vld_in) new_spin <= decide;
      flip_stb <= vld_in && (decide != ctr_in);
    end
  end
endmodule

// File: rtl/spin_accept_unit.sv
module spin_accept_unit
  import spin_accept_pkg::*;
#(
  parameter int PROB_W = 32,
  parameter int ADDR_W = 10,
  parameter int SQ_W   = 8,
  parameter int NEAR_W = 6,
  parameter int FAR_W  = 6,
  localparam int NBR_W = (SQ_W > NEAR_W + FAR_W) ? SQ_W : NEAR_W + FAR_W,
  localparam int CNT_W = $clog2(FAR_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lat_sel,
  input  logic              in_vld,
  input  logic              center_spin,
  input  logic [NBR_W-1:0]  nbr_bits,
  input  logic [PROB_W-1:0] rnd_word,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [PROB_W-1:0] host_wdata,
  output logic [PROB_W-1:0] host_rdata,
  output logic              out_vld,
  output logic              new_spin,
  output logic              flip_stb
);
  logic [ADDR_W-1:0] lut_addr;
  logic [PROB_W-1:0] s1_prob;
  logic [PROB_W-1:0] s1_rnd;
  logic              s1_vld;
  logic              s1_ctr;

  nbr_addr_former #(
    .ADDR_W(ADDR_W), .NBR_W(NBR_W), .SQ_W(SQ_W),
    .NEAR_W(NEAR_W), .FAR_W(FAR_W), .CNT_W(CNT_W)
  ) former_i (
    .lat    (lattice_e'(lat_sel)),
    .center (center_spin),
    .nbr    (nbr_bits),
    .addr   (lut_addr)
  );

  prob_table #(.ADDR_W(ADDR_W), .DATA_W(PROB_W)) table_i (
    .clk     (clk),
    .lk_addr (lut_addr),
    .lk_data (s1_prob),
    .h_we    (host_we),
    .h_addr  (host_addr),
    .h_wdata (host_wdata),
    .h_rdata (host_rdata)
  );

  // stage 1: side data travels with the table read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_ctr <= 1'b0;
      s1_rnd <= '0;
    end else begin
      s1_vld <= in_vld;
      s1_ctr <= center_spin;
      s1_rnd <= rnd_word;
    end
  end

  // stage 2: compare and strobe
  accept_compare #(.PROB_W(PROB_W)) cmp_i (
    .clk      (clk),
    .rst      (rst),
    .vld_in   (s1_vld),
    .ctr_in   (s1_ctr),
    .prob     (s1_prob),
    .rnd      (s1_rnd),
    .out_vld  (out_vld),
    .new_spin (new_spin),
    .flip_stb (flip_stb)
  );
endmodule

// File: rtl/spin_accept_chk.sv
module spin_accept_chk #(
  parameter int PROB_W = 32,
  parameter int ADDR_W = 10,
  parameter int SQ_W   = 8,
  parameter int FAR_W  = 6,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              lat_sel,
  input logic              in_vld,
  input logic              center_spin,
  input logic [ADDR_W-1:0] lut_addr,
  input logic [PROB_W-1:0] s1_prob,
  input logic [PROB_W-1:0] s1_rnd,
  input logic              out_vld,
  input logic              new_spin,
  input logic              flip_stb
);
  localparam logic [ADDR_W-1:0] CNT_MASK = ADDR_W'((1 << CNT_W) - 1);
  localparam int SQ_SPAN = 1 << (SQ_W + 1);

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  AST_SQ_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !lat_sel) |-> (int'(lut_addr) < SQ_SPAN)); // R1

  AST_TRI_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (in_vld && lat_sel) |-> (int'(lut_addr & CNT_MASK) <= FAR_W)); // R3

  AST_CMP_RESULT: assert property (@(posedge clk) disable iff (rst || warm != 2'd2)
    out_vld |-> (new_spin == ($past(s1_prob) > $past(s1_rnd)))); // R4

  AST_FLIP_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    flip_stb |-> out_vld); // R5

  AST_FLIP_MATCHES_CHANGE: assert property (@(posedge clk) disable iff (rst || warm != 2'd2)
    out_vld |-> (flip_stb == (new_spin != $past(center_spin, 2)))); // R5

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst || warm != 2'd2)
    out_vld == $past(in_vld, 2)); // R6
endmodule

bind spin_accept_unit spin_accept_chk #(
  .PROB_W(PROB_W), .ADDR_W(ADDR_W), .SQ_W(SQ_W), .FAR_W(FAR_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .lat_sel(lat_sel), .in_vld(in_vld),
  .center_spin(center_spin), .lut_addr(lut_addr), .s1_prob(s1_prob),
  .s1_rnd(s1_rnd), .out_vld(out_vld), .new_spin(new_spin), .flip_stb(flip_stb)
);

// File: tb/spin_accept_unit_tb_top.sv
module spin_accept_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lat_sel = 1'b0;
  logic        in_vld = 1'b0;
  logic        center_spin = 1'b0;
  logic [11:0] nbr_bits = '0;
  logic [31:0] rnd_word = '0;
  logic        host_we = 1'b0;
  logic [9:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        out_vld, new_spin, flip_stb;

  int checks = 0;
  int bad = 0;

  typedef struct {
    bit    vld;
    bit    spin;
    bit    flip;
    string tag;
  } exp_t;

  exp_t        pipe_q[$];
  int unsigned model_mem[1024];
  string       cur_tag = "R9";

  always #4 clk = ~clk;

  spin_accept_unit dut_i (
    .clk(clk), .rst(rst), .lat_sel(lat_sel), .in_vld(in_vld),
    .center_spin(center_spin), .nbr_bits(nbr_bits), .rnd_word(rnd_word),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .out_vld(out_vld), .new_spin(new_spin),
    .flip_stb(flip_stb)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int model_index(bit sel, bit c, int n);
    int cnt = 0;
    if (!sel) return c * 256 + (n % 256);
    for (int i = 6; i < 12; i++) if (((n >> i) & 1) != int'(c)) cnt++;
    return c * 512 + (n % 64) * 8 + cnt;
  endfunction

  // one clock: queue expectation, wait, compare the result due now
  task automatic step(input bit chk_rd);
    exp_t e;
    exp_t got;
    int unsigned exp_rd;
    e.vld = in_vld; e.tag = cur_tag; e.spin = 0; e.flip = 0;
    if (in_vld) begin
      e.spin = model_mem[model_index(lat_sel, center_spin, int'(nbr_bits))] > rnd_word;
      e.flip = e.spin != center_spin;
    end
    pipe_q.push_back(e);
    exp_rd = model_mem[host_addr];
    if (host_we) model_mem[host_addr] = host_wdata;
    @(negedge clk);
    if (chk_rd) chk(host_rdata == exp_rd, "R7", "host_rdata", host_rdata, exp_rd);
    got = pipe_q.pop_front();
    if (got.vld) begin
      chk(out_vld == 1'b1, "R6", "out_vld", out_vld, 1);
      chk(new_spin == got.spin, got.tag, "new_spin", new_spin, got.spin);
      chk(flip_stb == got.flip, "R5", "flip_stb", flip_stb, got.flip);
    end else begin
      chk(out_vld == 1'b0 && flip_stb == 1'b0, "R9", "out_vld|flip_stb",
          {out_vld, flip_stb}, 0);
    end
  endtask

  task automatic look(input bit sel, input bit c, input int n, input int unsigned r,
                      input string tag);
    in_vld = 1; lat_sel = sel; center_spin = c; nbr_bits = 12'(n); rnd_word = r;
    cur_tag = tag;
    step(0);
    in_vld = 0;
  endtask

  // pair of lookups that pins the index: rnd equal to the entry and one below
  task automatic pin_index(input bit sel, input bit c, input int n, input string tag);
    int unsigned p = model_mem[model_index(sel, c, n)];
    look(sel, c, n, p, tag);
    look(sel, c, n, p - 1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    // R8: reset dominates a valid input
    in_vld = 1; center_spin = 1; nbr_bits = 12'hABC; rnd_word = 0;
    repeat (3) @(negedge clk);
    chk(out_vld == 0 && flip_stb == 0, "R8", "outputs in reset", {out_vld, flip_stb}, 0);
    pipe_q.push_back('{vld: 0, spin: 0, flip: 0, tag: "R8"});
    rst = 0; in_vld = 0;

    // table load, distinct entries
    for (int a = 0; a < 1024; a++) begin
      host_we = 1; host_addr = 10'(a); host_wdata = 32'(a) * 32'h9E3779B9;
      step(0);
    end
    host_we = 0;
    // R7: readback
    for (int i = 0; i < 12; i++) begin
      host_addr = 10'($urandom % 1024);
      step(1);
    end
    // R7: read-before-write then new value
    host_addr = 10'd77; host_we = 1; host_wdata = 32'h1234_5678;
    step(1);
    host_we = 0;
    step(1);

    // R1: square layout, upper neighbor bits random
    for (int i = 0; i < 30; i++) pin_index(0, 1'($urandom), int'($urandom % 4096), "R1");
    // R1: upper neighbor bits have no effect
    for (int u = 0; u < 16; u++) pin_index(0, 1, (u << 8) | 8'h5A, "R1");

    // R2: triangular layout
    for (int i = 0; i < 30; i++) pin_index(1, 1'($urandom), int'($urandom % 4096), "R2");

    // R3: every unlike count, both central spins, two arrangements each
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k <= 6; k++) begin
        int m  = (1 << k) - 1;
        int m2 = (m << (6 - k)) & 63;
        int f1 = (c != 0) ? (~m & 63) : m;
        int f2 = (c != 0) ? (~m2 & 63) : m2;
        pin_index(1, 1'(c), (f1 << 6) | 6'h2B, "R3");
        pin_index(1, 1'(c), (f2 << 6) | 6'h2B, "R3");
      end
    end

    // R4: compare edges and random words, with gaps between some lookups
    look(0, 0, 0, 32'h0, "R4");
    look(0, 0, 0, 32'hFFFF_FFFF, "R4");
    look(1, 1, 12'hFFF, 32'h0, "R4");
    look(1, 0, 12'h001, 32'hFFFF_FFFF, "R4");
    for (int i = 0; i < 40; i++) begin
      look(1'($urandom), 1'($urandom), int'($urandom % 4096), $urandom, "R4");
      if (i % 5 == 0) step(0);
    end

    // drain
    step(0);
    step(0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule